// File: doc/BRIEF.md
# Channel Command Register Unit with Global Reset

This unit is the host-side command front end of a four-channel peripheral controller. A host on a simple synchronous register bus selects a target channel through a selector register. It then posts a one-byte command into a command register. The command register reads non-zero while the command runs, and it returns to zero when a fixed-latency stub executor reports completion. The host therefore polls for zero before it posts the next command. Channel 0 is the parallel channel and has no command register. Channels 2 and 3 are the serial channels.

One command code, 0x81, is the full-chip reset. It is honoured only while a serial channel is selected. It does not use the clear-on-completion handshake. Instead, it zeroes all interface registers and holds the FIFO flush and every per-channel disable for a fixed sequence length. When the sequence ends, it loads a revision code into a separate read-only register. The host learns that the reset has finished by watching that register change from zero. The synchronous reset input runs the same sequence.

Top module: `chan_cmd_unit`

## Requirements
- R1: A write to address 1 takes effect only when the selector is 1, 2 or 3, the command register reads zero, and the data is non-zero and not 0x81. In that case the command register reads the written value from the next cycle. exec_start is high for exactly that one cycle, with exec_chan equal to the selector and exec_code equal to the data.
- R2: An accepted command reads back non-zero for exactly EXEC_LAT cycles and then reads zero.
- R3: A write to address 1 is dropped when the command register is non-zero and a channel other than 0 is selected. The register keeps its value and no exec_start pulse is produced. Bit 0 of address 3 (the sticky error flag) is set and stays set until the next global reset.
- R4: While the selector is 0, a write to address 1 has no effect: no exec_start, no change to the error flag, and no reset. Address 1 reads zero while the selector is 0.
- R5: Writing 0x81 to address 1 with selector 2 or 3 while the command register reads zero starts a global reset. In the next cycle the selector, command register and error flag read zero. fifo_flush and all chan_disable bits are high for exactly RST_CYCLES cycles.
- R6: The revision register at address 2 reads zero from the first cycle of any global reset sequence. It reads REV_CODE from the cycle in which fifo_flush falls. The command register plays no part in signalling this completion.
- R7: Writing 0x81 with selector 0 or 1 is ignored. No reset starts, the command register stays zero, no exec_start pulse is produced, and the error flag does not change.
- R8: While rst is high, fifo_flush and all chan_disable bits are high and every register reads zero. After rst falls, they stay high for RST_CYCLES more cycles, and then the revision register reads REV_CODE.
- R9: Bus writes made while fifo_flush is high are ignored.
- R10: Writing zero to an idle command register leaves it zero and produces no exec_start.
- R11: A write to address 0 stores the low two data bits as the selector. Address 0 reads that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, runs the global reset sequence |
| bus_addr | input | 2 | Register address: 0 selector, 1 command, 2 revision, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| exec_start | output | 1 | One-cycle pulse when a command is issued to the executor |
| exec_chan | output | 2 | Channel of the issued command |
| exec_code | output | 8 | Code of the issued command |
| fifo_flush | output | 1 | High throughout the global reset sequence |
| chan_disable | output | 4 | Per-channel disable, high throughout the global reset sequence |

## Verification
The bench builds the unit with EXEC_LAT = 5, RST_CYCLES = 9 and REV_CODE = 0xA5. These short windows let each cycle of a command's busy period and of the reset sequence be sampled and counted exactly, including both edges of each window. The short windows also let random traffic overlap commands with writes and with back-to-back global resets many times. The non-zero revision code makes its load at the end of the sequence distinct from the zero it holds during the sequence.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

    localparam int DATA_W = 8;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    localparam logic [DATA_W-1:0] GLOBAL_RESET_CODE = 8'h81;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CH_W-1:0]   chan_t;

    typedef enum logic [1:0] {
        ADR_SEL  = 2'd0,
        ADR_CMD  = 2'd1,
        ADR_REV  = 2'd2,
        ADR_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ISSUE,
        ACT_GRESET,
        ACT_REJECT
    } cmd_act_e;

    function automatic logic chan_is_serial(chan_t ch);
        return (ch == chan_t'(2)) || (ch == chan_t'(3));
    endfunction

    function automatic logic chan_has_cmd(chan_t ch);
        return ch != chan_t'(0);
    endfunction

    // Decide what a write to the command address does.
    function automatic cmd_act_e classify(chan_t ch, logic busy, byte_t code);
        cmd_act_e act;
        if (!chan_has_cmd(ch))
            act = ACT_NONE;
        else if (busy)
            act = ACT_REJECT;
        else if (code == '0)
            act = ACT_NONE;
        else if (code == GLOBAL_RESET_CODE)
            act = chan_is_serial(ch) ? ACT_GRESET : ACT_NONE;
        else
            act = ACT_ISSUE;
        return act;
    endfunction

endpackage

// File: rtl/chan_exec_stub.sv
module chan_exec_stub #(
    parameter int EXEC_LAT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(EXEC_LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || kill)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(EXEC_LAT);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/chan_reset_seq.sv
module chan_reset_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start)
            cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/chan_cmd_unit.sv
module chan_cmd_unit
    import chan_cmd_pkg::*;
#(
    parameter int          EXEC_LAT   = 8,
    parameter int          RST_CYCLES = 16,
    parameter logic [7:0]  REV_CODE   = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 exec_start,
    output logic [CH_W-1:0]      exec_chan,
    output logic [DATA_W-1:0]    exec_code,
    output logic                 fifo_flush,
    output logic [NUM_CH-1:0]    chan_disable
);
    reg_addr_e addr;
    chan_t     sel_q;
    byte_t     cmd_q;
    byte_t     rev_q;
    logic      err_q;
    logic      seq_busy;
    logic      seq_last;
    logic      exec_done;
    logic      wr_ok;
    cmd_act_e  act;
    logic      do_issue;
    logic      do_greset;
    logic      do_reject;

    assign addr  = reg_addr_e'(bus_addr);
    assign wr_ok = bus_wr && !seq_busy;

    always_comb begin
        act = ACT_NONE;
        if (wr_ok && addr == ADR_CMD)
            act = classify(sel_q, cmd_q != '0, bus_wdata);
    end

    assign do_issue  = (act == ACT_ISSUE);
    assign do_greset = (act == ACT_GRESET);
    assign do_reject = (act == ACT_REJECT);

    chan_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (do_greset),
        .busy  (seq_busy),
        .last  (seq_last)
    );

    chan_exec_stub #(.EXEC_LAT(EXEC_LAT)) u_exec (
        .clk   (clk),
        .rst   (rst),
        .kill  (do_greset),
        .start (do_issue),
        .done  (exec_done)
    );

    always_ff @(posedge clk) begin
        if (rst || do_greset) begin
            sel_q <= '0;
            cmd_q <= '0;
            err_q <= 1'b0;
            rev_q <= '0;
        end else begin
            if (wr_ok && addr == ADR_SEL)
                sel_q <= bus_wdata[CH_W-1:0];
            if (do_issue)
                cmd_q <= bus_wdata;
            else if (exec_done)
                cmd_q <= '0;
            if (do_reject)
                err_q <= 1'b1;
            if (seq_last)
                rev_q <= REV_CODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_start <= 1'b0;
            exec_chan  <= '0;
            exec_code  <= '0;
        end else begin
            exec_start <= do_issue;
            if (do_issue) begin
                exec_chan <= sel_q;
                exec_code <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr)
                ADR_SEL:  bus_rdata = DATA_W'(sel_q);
                ADR_CMD:  bus_rdata = chan_has_cmd(sel_q) ? cmd_q : '0;
                ADR_REV:  bus_rdata = rev_q;
                ADR_STAT: bus_rdata = DATA_W'(err_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign fifo_flush = seq_busy;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dis
        assign chan_disable[i] = seq_busy;
    end
endmodule

// File: rtl/chan_cmd_checker.sv
module chan_cmd_checker
    import chan_cmd_pkg::*;
#(
    parameter logic [7:0] REV_CODE = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic        fifo_flush,
    input logic        exec_start,
    input logic [CH_W-1:0] exec_chan,
    input logic [7:0]  rev_q,
    input logic [7:0]  cmd_q,
    input logic        err_q
);
    AST_REV_ZERO_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> rev_q == 8'h00); // R6

    AST_REV_LOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_flush) |-> rev_q == REV_CODE); // R6

    AST_CMD_CLEAR_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> cmd_q == 8'h00); // R5

    AST_NO_PARALLEL_ISSUE: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> exec_chan != '0); // R4

    AST_ISSUE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> $past(cmd_q) == 8'h00); // R1

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !fifo_flush) |=> (err_q || fifo_flush)); // R3
endmodule

bind chan_cmd_unit chan_cmd_checker #(.REV_CODE(REV_CODE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_flush (fifo_flush),
    .exec_start (exec_start),
    .exec_chan  (exec_chan),
    .rev_q      (rev_q),
    .cmd_q      (cmd_q),
    .err_q      (err_q)
);

// File: tb/chan_cmd_unit_bench.sv
`timescale 1ns/10ps
module chan_cmd_unit_bench;
    localparam int         P_EXEC = 5;
    localparam int         P_RST  = 9;
    localparam logic [7:0] P_REV  = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       exec_start;
    logic [1:0] exec_chan;
    logic [7:0] exec_code;
    logic       fifo_flush;
    logic [3:0] chan_disable;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    chan_cmd_unit #(.EXEC_LAT(P_EXEC), .RST_CYCLES(P_RST), .REV_CODE(P_REV)) u_chan_cmd_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .exec_start(exec_start), .exec_chan(exec_chan), .exec_code(exec_code),
        .fifo_flush(fifo_flush), .chan_disable(chan_disable)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // reference model state
    logic [1:0] m_sel;
    logic [7:0] m_cmd, m_rev, m_code;
    logic       m_err, m_start;
    logic [1:0] m_chan;
    int         m_rcnt, m_ecnt;

    task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d);
        logic [7:0] old_cmd;
        m_start = 1'b0;
        if (m_rcnt != 0) begin
            if (m_rcnt == 1) m_rev = P_REV;
            m_rcnt--;
            return;
        end
        old_cmd = m_cmd;
        if (m_ecnt != 0) begin
            if (m_ecnt == 1) m_cmd = 8'h00;
            m_ecnt--;
        end
        if (!w) return;
        if (a == 2'd0) m_sel = d[1:0];
        else if (a == 2'd1 && m_sel != 2'd0) begin
            if (old_cmd != 8'h00) m_err = 1'b1;
            else if (d == 8'h81) begin
                if (m_sel >= 2'd2) begin
                    m_sel = 0; m_cmd = 0; m_err = 0; m_rev = 0;
                    m_rcnt = P_RST; m_ecnt = 0;
                end
            end else if (d != 8'h00) begin
                m_cmd = d; m_ecnt = P_EXEC; m_start = 1'b1;
                m_chan = m_sel; m_code = d;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd2718));

        // R8: reset state
        repeat (4) @(negedge clk);
        check("R8 flush in rst", {31'b0, fifo_flush}, 1);
        check("R8 disable in rst", {28'b0, chan_disable}, 4'hF);
        rd(2'd2, v); check("R8 rev in rst", v, 0);
        rd(2'd0, v); check("R8 sel in rst", v, 0);
        rst = 1'b0;
        for (int k = 0; k < P_RST; k++) begin
            check("R8 flush after rst", {31'b0, fifo_flush}, 1);
            rd(2'd2, v); check("R8 rev zero after rst", v, 0);
            @(negedge clk);
        end
        check("R8 flush end", {31'b0, fifo_flush}, 0);
        rd(2'd2, v); check("R8 rev loaded", v, P_REV);

        // R11
        wr(2'd0, 8'hFE);
        rd(2'd0, v); check("R11 sel readback", v, 8'h02);

        // R10
        wr(2'd1, 8'h00);
        check("R10 no start", {31'b0, exec_start}, 0);
        rd(2'd1, v); check("R10 cmd zero", v, 0);

        // R1, R2
        wr(2'd1, 8'h3C);
        check("R1 start", {31'b0, exec_start}, 1);
        check("R1 chan", {30'b0, exec_chan}, 2);
        check("R1 code", {24'b0, exec_code}, 8'h3C);
        for (int k = 0; k < P_EXEC; k++) begin
            rd(2'd1, v); check("R2 cmd busy", v, 8'h3C);
            if (k == 1) check("R1 single pulse", {31'b0, exec_start}, 0);
            @(negedge clk);
        end
        rd(2'd1, v); check("R2 cmd cleared", v, 0);

        // R3
        wr(2'd1, 8'h11);
        wr(2'd1, 8'h22);
        check("R3 no start on drop", {31'b0, exec_start}, 0);
        rd(2'd1, v); check("R3 cmd kept", v, 8'h11);
        rd(2'd3, v); check("R3 err set", v, 1);
        repeat (P_EXEC) @(negedge clk);
        rd(2'd1, v); check("R3 cmd done", v, 0);
        rd(2'd3, v); check("R3 err sticky", v, 1);

        // R4, R7 on channel 0
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h55);
        check("R4 no start", {31'b0, exec_start}, 0);
        rd(2'd1, v); check("R4 cmd reads zero", v, 0);
        wr(2'd1, 8'h81);
        check("R7 ch0 no reset", {31'b0, fifo_flush}, 0);
        rd(2'd3, v); check("R4 err unchanged", v, 1);

        // R7 on channel 1
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h81);
        check("R7 ch1 no reset", {31'b0, fifo_flush}, 0);
        check("R7 ch1 no start", {31'b0, exec_start}, 0);
        rd(2'd1, v); check("R7 ch1 cmd zero", v, 0);
        rd(2'd2, v); check("R7 rev kept", v, P_REV);

        // R5, R6 on channel 3
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h81);
        rd(2'd0, v); check("R5 sel cleared", v, 0);
        rd(2'd3, v); check("R5 err cleared", v, 0);
        for (int k = 0; k < P_RST; k++) begin
            check("R5 flush", {31'b0, fifo_flush}, 1);
            check("R5 disable", {28'b0, chan_disable}, 4'hF);
            rd(2'd2, v); check("R6 rev zero", v, 0);
            @(negedge clk);
        end
        check("R5 flush end", {31'b0, fifo_flush}, 0);
        check("R5 disable end", {28'b0, chan_disable}, 0);
        rd(2'd2, v); check("R6 rev loaded", v, P_REV);
        rd(2'd1, v); check("R6 cmd stays zero", v, 0);

        // R9 on channel 2
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h81);
        wr(2'd0, 8'h01);
        check("R9 still flushing", {31'b0, fifo_flush}, 1);
        rd(2'd0, v); check("R9 sel write ignored", v, 0);
        while (fifo_flush) @(negedge clk);

        // random phase against the model
        m_sel = 0; m_cmd = 0; m_err = 0; m_rev = P_REV; m_rcnt = 0; m_ecnt = 0;
        m_start = 0; m_chan = 0; m_code = 0;
        for (int i = 0; i < 1500; i++) begin
            logic w; logic [1:0] a; logic [7:0] d; int r;
            rd(2'd0, v); check("R11 rand sel", v, {6'b0, m_sel});
            rd(2'd1, v); check("R2 rand cmd", v, (m_sel == 0) ? 8'h00 : m_cmd);
            rd(2'd2, v); check("R6 rand rev", v, m_rev);
            rd(2'd3, v); check("R3 rand err", v, {7'b0, m_err});
            check("R5 rand flush", {31'b0, fifo_flush}, (m_rcnt != 0) ? 1 : 0);
            check("R1 rand start", {31'b0, exec_start}, {31'b0, m_start});
            if (m_start) begin
                check("R1 rand chan", {30'b0, exec_chan}, {30'b0, m_chan});
                check("R1 rand code", {24'b0, exec_code}, {24'b0, m_code});
            end
            w = ($urandom_range(0, 1) == 1);
            r = $urandom_range(0, 9);
            a = (r < 4) ? 2'd1 : (r < 7) ? 2'd0 : 2'($urandom_range(0, 3));
            r = $urandom_range(0, 9);
            d = (r < 2) ? 8'h81 : (r == 2) ? 8'h00 : 8'($urandom_range(0, 255));
            bus_addr = a; bus_wdata = d; bus_wr = w;
            model_step(w, a, d);
            @(negedge clk);
            bus_wr = 1'b0;
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule